// File: doc/BRIEF.md
# Conditional Compare and Select Unit

This unit handles the two flag-predicated integer operations of a processor execute stage. It holds an NZCV flag register and tests a 4-bit condition code against it. A conditional compare then either computes fresh flags from an addition or a subtraction of its operands, or loads a 4-bit default flag value supplied with the operation. A conditional select returns the first operand when the condition holds. When it does not, it returns a transformed second operand: the operand itself, the operand plus one, its bitwise inverse, or its two's-complement negation.

The datapath is `DATA_W` bits wide. A narrow-mode input makes the unit work on the low `DATA_W/2` bits. The select result is combinational from the inputs and the current flags. New flags are written into the register at the next rising clock edge, and only by compare operations.

Top module: `ccs_unit`

## Requirements
- R1: After a synchronous active-low reset, the flag register `flags_o` reads 0000 and the idle operation (`op_i` = 000) drives `result_o` to zero.
- R2: `flags_o` is laid out {N,Z,C,V} with N at bit 3. `cond_i` is decoded as follows. Bits [3:1] choose the base test: 000 Z set, 001 C set, 010 N set, 011 V set, 100 C set and Z clear, 101 N equal to V, 110 Z clear and N equal to V. Bit 0 = 1 inverts the base test. Codes 1110 and 1111 always pass.
- R3: A compare-negative (`op_i` = 001) whose condition passes writes flags for op1 + B: N is the result MSB, Z is set for a zero result, C is the carry out, and V is signed overflow.
- R4: A compare (`op_i` = 010) whose condition passes writes flags for op1 − B: C = 1 when op1 ≥ B unsigned (no borrow), and V is signed overflow of the subtraction.
- R5: A compare whose condition fails writes `dflt_nzcv_i` into the flags: N from bit 3, Z from bit 2, C from bit 1, V from bit 0.
- R6: For compares, B is `op2_i` when `use_imm_i` = 0 and the zero-extended `imm_i` when `use_imm_i` = 1.
- R7: Compares drive `result_o` to zero. The idle and select operations (`op_i` 000, 100 to 111) leave the flags unchanged.
- R8: A select whose condition passes returns `op1_i`.
- R9: A select whose condition fails returns `op2_i` for `op_i` = 100, `op2_i`+1 for 101, ~`op2_i` for 110 and −`op2_i` for 111, modulo the active width.
- R10: With `narrow_i` = 1, compares use only the low `DATA_W/2` operand bits and take their flags at bit `DATA_W/2`−1. The select result is zero in its upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code (see R3, R4, R7, R9) |
| narrow_i | input | 1 | Half-width mode |
| cond_i | input | 4 | Condition code |
| dflt_nzcv_i | input | 4 | Flags loaded by a compare whose condition fails |
| use_imm_i | input | 1 | Compare second operand from the immediate |
| imm_i | input | IMM_W | Compare immediate, zero-extended |
| op1_i | input | DATA_W | First operand |
| op2_i | input | DATA_W | Second operand |
| result_o | output | DATA_W | Select result, zero for other operations |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The flag register can only be set through the unit's own operations, so the hardest thing is to put the flags into all sixteen states before each of the sixteen condition codes is tested. The stimulus first runs an always-passing compare of 1 against 0, which leaves Z clear. It then issues an equal-condition compare that must fail, and that compare loads the wanted flag value from the default field. A select of 1 against 0 then shows each pass or fail result at the result port. The sweep covers every flag state with every condition code.

// File: rtl/ccs_pkg.sv
// Shared types for the conditional compare and select unit.
// Assumes the operation codes below are what the decoder feeding the unit uses.
package ccs_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'b000,
        OP_CMN  = 3'b001,
        OP_CMP  = 3'b010,
        OP_SEL  = 3'b100,
        OP_SINC = 3'b101,
        OP_SINV = 3'b110,
        OP_SNEG = 3'b111
    } ccs_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/ccs_cond_eval.sv
// Condition evaluator: tests a 4-bit condition code against the NZCV flags.
// Assumes bits [3:1] choose the base test and bit 0 inverts it, except for
// base 111, which always passes.
module ccs_cond_eval
    import ccs_pkg::*;
(
    input  nzcv_t      flags_i,
    input  logic [3:0] code_i,
    output logic       pass_o
);

    logic base;

    // Choose the base test from the upper three code bits.
    always_comb begin
        unique case (code_i[3:1])
            3'b000:  base = flags_i.z;
            3'b001:  base = flags_i.c;
            3'b010:  base = flags_i.n;
            3'b011:  base = flags_i.v;
            3'b100:  base = flags_i.c & ~flags_i.z;
            3'b101:  base = (flags_i.n == flags_i.v);
            3'b110:  base = ~flags_i.z & (flags_i.n == flags_i.v);
            default: base = 1'b1;
        endcase
    end

    // Apply the inversion bit; the always-pass pair ignores it.
    always_comb begin
        if (code_i[3:1] == 3'b111) pass_o = 1'b1;
        else                       pass_o = base ^ code_i[0];
    end

endmodule

// File: rtl/ccs_flag_calc.sv
// Flag calculator: one adder lane per width (half and full) computes the
// NZCV flags of a + b or a - b, and narrow_i picks the lane.
// Assumes DATA_W is even; a subtraction is done as a + ~b + 1.
module ccs_flag_calc
    import ccs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              narrow_i,
    output nzcv_t             flags_o
);

    localparam int HALF_W = DATA_W / 2;

    nzcv_t lane_flags [2];

    // Lane 0 works on HALF_W bits, lane 1 on DATA_W bits.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF_W : DATA_W;
        logic [LW-1:0] la;
        logic [LW-1:0] lb;
        logic [LW:0]   sum;

        assign la  = a_i[LW-1:0];
        assign lb  = sub_i ? ~b_i[LW-1:0] : b_i[LW-1:0];
        assign sum = {1'b0, la} + {1'b0, lb} + {{LW{1'b0}}, sub_i};

        // Flags of this lane's sum.
        always_comb begin
            lane_flags[g].n = sum[LW-1];
            lane_flags[g].z = (sum[LW-1:0] == '0);
            lane_flags[g].c = sum[LW];
            lane_flags[g].v = (la[LW-1] == lb[LW-1]) && (sum[LW-1] != la[LW-1]);
        end
    end

    // Take the flags of the active width.
    always_comb begin
        flags_o = narrow_i ? lane_flags[0] : lane_flags[1];
    end

endmodule

// File: rtl/ccs_alt_sel.sv
// Alternate value generator for conditional select: passes op2, op2 + 1,
// ~op2 or -op2 according to a 2-bit variant.
// Assumes variant 00 = plain, 01 = increment, 10 = invert, 11 = negate.
module ccs_alt_sel #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] op2_i,
    input  logic [1:0]        variant_i,
    output logic [DATA_W-1:0] alt_o
);

    // Form the alternate value for the chosen variant.
    always_comb begin
        unique case (variant_i)
            2'b00:   alt_o = op2_i;
            2'b01:   alt_o = op2_i + DATA_W'(1);
            2'b10:   alt_o = ~op2_i;
            default: alt_o = '0 - op2_i;
        endcase
    end

endmodule

// File: rtl/ccs_unit.sv
// Conditional compare and select unit. It holds the NZCV flag register,
// evaluates the condition against it, and then either writes new flags
// (compares) or produces a result (selects).
// Assumes IMM_W < DATA_W and an even DATA_W. The result is combinational;
// the flags update at the next rising edge.
module ccs_unit
    import ccs_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              narrow_i,
    input  logic [3:0]        cond_i,
    input  logic [3:0]        dflt_nzcv_i,
    input  logic              use_imm_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] op1_i,
    input  logic [DATA_W-1:0] op2_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    ccs_op_e           op;
    nzcv_t             flags_q;
    nzcv_t             cmp_flags;
    logic              cond_pass;
    logic              is_cmp;
    logic              is_sel;
    logic [DATA_W-1:0] cmp_b;
    logic [DATA_W-1:0] alt_val;
    logic [DATA_W-1:0] sel_val;

    // Decode the operation class.
    always_comb begin
        op     = ccs_op_e'(op_i);
        is_cmp = (op == OP_CMN) || (op == OP_CMP);
        is_sel = op_i[2];
    end

    // Pick the second compare operand.
    always_comb begin
        cmp_b = use_imm_i ? {{(DATA_W-IMM_W){1'b0}}, imm_i} : op2_i;
    end

    ccs_cond_eval u_cond (
        .flags_i (flags_q),
        .code_i  (cond_i),
        .pass_o  (cond_pass)
    );

    ccs_flag_calc #(.DATA_W(DATA_W)) u_flags (
        .a_i      (op1_i),
        .b_i      (cmp_b),
        .sub_i    (op == OP_CMP),
        .narrow_i (narrow_i),
        .flags_o  (cmp_flags)
    );

    ccs_alt_sel #(.DATA_W(DATA_W)) u_alt (
        .op2_i     (op2_i),
        .variant_i (op_i[1:0]),
        .alt_o     (alt_val)
    );

    // Select result, masked to the active width; zero for non-select ops.
    always_comb begin
        sel_val  = cond_pass ? op1_i : alt_val;
        result_o = is_sel ? (narrow_i ? (sel_val & LOW_MASK) : sel_val) : '0;
    end

    // Flag register: written only by compares, from the sum or the default.
    always_ff @(posedge clk) begin
        if (!rst_n)      flags_q <= '0;
        else if (is_cmp) flags_q <= cond_pass ? cmp_flags : nzcv_t'(dflt_nzcv_i);
    end

    assign flags_o = flags_q;

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmp |=> flags_o == $past(flags_o));

    // R5
    default_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmp && !cond_pass) |=> flags_o == $past(dflt_nzcv_i));

    // R7
    cmp_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> result_o == '0);

    // R10
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && narrow_i) |-> (result_o & ~LOW_MASK) == '0);

    // R2
    always_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i[3:1] == 3'b111) |-> cond_pass);

    // R8
    sel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sel && cond_pass && !narrow_i) |-> result_o == op1_i);

endmodule

// File: tb/ccs_unit_tb_top.sv
// Bench: near-exhaustive sweeps of an 8-bit build of the unit, with the
// expected values computed arithmetically.
module ccs_unit_tb_top;

    localparam int DW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = 3'b000;
    logic          narrow = 1'b0;
    logic [3:0]    cond = 4'h0;
    logic [3:0]    dflt = 4'h0;
    logic          use_imm = 1'b0;
    logic [IW-1:0] imm = '0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic [DW-1:0] result;
    logic [3:0]    flags;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    ccs_unit #(.DATA_W(DW), .IMM_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .narrow_i(narrow), .cond_i(cond),
        .dflt_nzcv_i(dflt), .use_imm_i(use_imm), .imm_i(imm),
        .op1_i(a), .op2_i(b), .result_o(result), .flags_o(flags)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at the current negedge; return at the next negedge.
    task automatic run(input logic [2:0] o, input logic [3:0] c, input logic [3:0] d,
                       input logic ui, input logic [IW-1:0] im,
                       input logic [DW-1:0] x, input logic [DW-1:0] y, input logic nar);
        op = o; cond = c; dflt = d; use_imm = ui; imm = im; a = x; b = y; narrow = nar;
        #1;
        @(negedge clk);
    endtask

    // Put the flags into state f: always-pass compare 1 - 0 clears Z, then EQ fails.
    task automatic load_flags(input logic [3:0] f);
        run(3'b010, 4'hE, 4'h0, 1'b0, '0, 8'd1, 8'd0, 1'b0);
        run(3'b010, 4'h0, f, 1'b0, '0, 8'd0, 8'd0, 1'b0);
        check(flags == f, "R5", 64'(flags), 64'(f));
    endtask

    function automatic bit exp_cond(input logic [3:0] f, input logic [3:0] c);
        bit n, z, cy, v, r;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c[3:1])
            3'd0: r = z;
            3'd1: r = cy;
            3'd2: r = n;
            3'd3: r = v;
            3'd4: r = cy && !z;
            3'd5: r = (n == v);
            3'd6: r = !z && (n == v);
            default: return 1'b1;
        endcase
        return c[0] ? !r : r;
    endfunction

    function automatic logic [3:0] exp_cmp(input int x, input int y, input bit sub, input bit nar);
        int w, m, ua, ub, sa, sb, r, sr;
        bit n, z, cy, v;
        w = nar ? 4 : 8;
        m = 1 << w;
        ua = x % m; ub = y % m;
        sa = (ua >= m / 2) ? ua - m : ua;
        sb = (ub >= m / 2) ? ub - m : ub;
        if (sub) begin r = ua - ub; cy = (ua >= ub); sr = sa - sb; end
        else     begin r = ua + ub; cy = (r >= m);   sr = sa + sb; end
        v = (sr >= m / 2) || (sr < -(m / 2));
        r = ((r % m) + m) % m;
        n = (r >= m / 2);
        z = (r == 0);
        return {n, z, cy, v};
    endfunction

    function automatic logic [DW-1:0] exp_alt(input logic [2:0] o, input int y, input bit nar);
        int m, r;
        m = nar ? 16 : 256;
        case (o[1:0])
            2'd0: r = y;
            2'd1: r = y + 1;
            2'd2: r = (m - 1) - (y % m);
            default: r = m - (y % m);
        endcase
        return DW'(r % m);
    endfunction

    initial begin
        logic [3:0] ef;
        logic [DW-1:0] er;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and idle result
        run(3'b000, 4'h0, 4'hF, 1'b0, '0, 8'hAA, 8'h55, 1'b0);
        check(flags == 4'h0, "R1 flags", 64'(flags), 64'h0);
        op = 3'b000; #1;
        check(result == '0, "R1 result", 64'(result), 64'h0);
        @(negedge clk);

        // R2: every flag state against every condition code
        for (int f = 0; f < 16; f++) begin
            for (int c = 0; c < 16; c++) begin
                load_flags(4'(f));
                op = 3'b100; cond = 4'(c); a = 8'd1; b = 8'd0; narrow = 1'b0; #1;
                er = exp_cond(4'(f), 4'(c)) ? 8'd1 : 8'd0;
                check(result == er, $sformatf("R2 f=%h c=%h", f, c), 64'(result), 64'(er));
                @(negedge clk);
                check(flags == 4'(f), "R7 select keeps flags", 64'(flags), 64'(f));
            end
        end

        // R3 / R4: wide compares, condition always passes
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y += 5) begin
                for (int s = 0; s < 2; s++) begin
                    run(s ? 3'b010 : 3'b001, 4'hE, 4'h0, 1'b0, '0, 8'(x), 8'(y), 1'b0);
                    ef = exp_cmp(x, y, s[0], 1'b0);
                    check(flags == ef, s ? "R4" : "R3", 64'(flags), 64'(ef));
                end
            end
        end

        // R10: narrow compares with junk upper operand bits
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int s = 0; s < 2; s++) begin
                    run(s ? 3'b010 : 3'b001, 4'hF, 4'h0, 1'b0, '0, 8'(x | 8'hA0), 8'(y | 8'h50), 1'b1);
                    ef = exp_cmp(x, y, s[0], 1'b1);
                    check(flags == ef, "R10 narrow compare", 64'(flags), 64'(ef));
                end
            end
        end

        // R6: immediate replaces op2; R7: compare result is zero
        for (int i = 0; i < 16; i++) begin
            for (int x = 0; x < 256; x += 17) begin
                op = 3'b010; cond = 4'hE; use_imm = 1'b1; imm = 4'(i); a = 8'(x); b = 8'hFF; narrow = 1'b0; #1;
                check(result == '0, "R7 compare result", 64'(result), 64'h0);
                @(negedge clk);
                ef = exp_cmp(x, i, 1'b1, 1'b0);
                check(flags == ef, "R6", 64'(flags), 64'(ef));
            end
        end
        use_imm = 1'b0;

        // R7: idle leaves flags
        load_flags(4'h9);
        run(3'b000, 4'hE, 4'h6, 1'b0, '0, 8'd3, 8'd3, 1'b0);
        check(flags == 4'h9, "R7 idle keeps flags", 64'(flags), 64'h9);

        // R8 / R9 / R10: select variants, Z clear so EQ fails and NE passes
        load_flags(4'h0);
        for (int v = 4; v < 8; v++) begin
            for (int y = 0; y < 256; y++) begin
                for (int nar = 0; nar < 2; nar++) begin
                    op = 3'(v); cond = 4'h0; a = 8'h5A; b = 8'(y); narrow = nar[0]; #1;
                    er = exp_alt(3'(v), y, nar[0]);
                    check(result == er, nar ? "R10 narrow select" : "R9", 64'(result), 64'(er));
                    cond = 4'h1; #1;
                    er = nar ? 8'h0A : 8'h5A;
                    check(result == er, "R8", 64'(result), 64'(er));
                    @(negedge clk);
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule